// File: doc/BRIEF.md
# Timer Pin Function and Edge Capture Controller

This block owns the single I/O pin of one timer channel. A mode register selects what the pin does. In general-purpose mode the pin is an input, or it is driven low or high, and the high level can be released instead of driven when open-drain drive is selected. In capture mode a synchronised edge detector watches the pin for rising edges, falling edges or both. Each qualifying edge sets a sticky event flag, and the flag can raise an interrupt.

Software reaches the block through a small word-addressed register bus with two registers. The mode register sits at word address 0. The status register sits at word address 1: it holds the sticky flags, which are cleared by writing ones, and the synchronised pin level. The output-compare and PWM function codes are decoded only so that they leave the pin undriven. No waveform is generated.

Top module: `tpin_ctrl`

## Requirements
- R1: After reset, the mode register and the status flags read 0, `pin_oe` is 0, `pin_out` is 0 and `irq` is 0.
- R2: Mode register layout, read back at address 0: function code in bits 2:0, pin control in bits 5:4, interrupt enable in bit 8, open-drain select in bit 9, edge select in bits 17:16. All other bits read as 0.
- R3: With function code 4 (general-purpose), pin control 2'b10 drives the pin low (`pin_oe`=1, `pin_out`=0) and 2'b11 drives it high (`pin_oe`=1, `pin_out`=1).
- R4: With function code 4 and pin control bit 5 clear, the pin is an input (`pin_oe`=0).
- R5: When bit 9 is set and the pin is a general-purpose output, a value of 1 releases the pin (`pin_oe`=0) and a value of 0 pulls it low (`pin_oe`=1). `pin_out` is always 0 while bit 9 is set.
- R6: Function codes 0, 1, 2, 3, 5, 6 and 7 never enable the output driver.
- R7: Status bit 8 shows the pin level after a two-flop synchroniser. A change at `pin_in` is seen there two clock edges later.
- R8: Capture is active in function code 1, and in code 4 with the pin as an input. Edge select 01 flags rising edges, 10 flags falling edges, 11 flags both and 00 flags none. A qualifying edge sets status bit 0 one clock edge after it reaches the synchronised level.
- R9: A qualifying edge that arrives while status bit 0 is already set also sets status bit 1 (missed event).
- R10: Writing to address 1 clears each status flag whose write-data bit is 1 and leaves the others unchanged. If an event and its clear fall on the same edge, the event wins.
- R11: `irq` is high when bit 8 of the mode register is set and status bit 0 or bit 1 is set. Clearing bit 8 masks `irq` and keeps the flags.
- R12: Changing the edge select, or switching into a capture-active mode, does not by itself set a flag while the pin is steady.
- R13: When the pin is a general-purpose output, pin edges are not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address for read and write (0 mode, 1 status) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| pin_in | input | 1 | Pin level from the pad, asynchronous |
| pin_out | output | 1 | Value driven onto the pad |
| pin_oe | output | 1 | Pad output enable |
| irq | output | 1 | Capture interrupt request |

## Verification
The bench times the flag setting. It checks an event cleared in the same cycle it is set, which a clear-first design would lose, and it checks the two-edge synchroniser latency, which a design with one stage or three stages would miss. It also checks rewrites of the edge select and entry into capture mode while the pin is held high. A detector whose previous-level register runs only while capture is enabled would report a false edge there. Open-drain with value 1 must release the pad rather than drive it, and output mode must stop capture. Masking the interrupt must keep the pending flags, which a design that clears on mask would drop.

// File: rtl/tpin_pkg.sv
package tpin_pkg;
   localparam logic [2:0] FN_OFF     = 3'd0;
   localparam logic [2:0] FN_CAPTURE = 3'd1;
   localparam logic [2:0] FN_COMPARE = 3'd2;
   localparam logic [2:0] FN_PWM     = 3'd3;
   localparam logic [2:0] FN_GPIO    = 3'd4;

   localparam int FN_LSB    = 0;
   localparam int PCTL_LSB  = 4;
   localparam int IRQEN_BIT = 8;
   localparam int OD_BIT    = 9;
   localparam int EDGE_LSB  = 16;
   localparam int LEVEL_BIT = 8;
   localparam int FLAG_W    = 4;
   localparam int MIN_DATA_W = EDGE_LSB + 2;

   typedef struct packed {
      logic [1:0] edge_sel;
      logic       od;
      logic       irq_en;
      logic [1:0] pctl;
      logic [2:0] fn;
   } mode_t;
endpackage

// File: rtl/tpin_sync.sv
module tpin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tpin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tpin_capture.sv
module tpin_capture #(
   parameter int NFLAG = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             level,
   input  logic             cap_en,
   input  logic [1:0]       edge_sel,
   input  logic             clr_we,
   input  logic [NFLAG-1:0] clr_mask,
   output logic [NFLAG-1:0] flags
);
   if (NFLAG < 2) begin : g_bad_nflag
      $error("tpin_capture: NFLAG must be at least 2");
   end

   logic prev_level;
   logic rise, fall, evt;
   logic [1:0] clr;
   logic evt_flag, miss_flag;

   // previous level runs in every mode so a mode change cannot fake an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_level <= 1'b0;
      else        prev_level <= level;
   end

   assign rise = level & ~prev_level;
   assign fall = ~level & prev_level;
   assign evt  = cap_en & ((edge_sel[0] & rise) | (edge_sel[1] & fall));
   assign clr  = clr_we ? clr_mask[1:0] : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_flag  <= 1'b0;
         miss_flag <= 1'b0;
      end else begin
         evt_flag  <= evt | (evt_flag & ~clr[0]);
         miss_flag <= (evt & evt_flag) | (miss_flag & ~clr[1]);
      end
   end

   assign flags[0] = evt_flag;
   assign flags[1] = miss_flag;
   for (genvar i = 2; i < NFLAG; i++) begin : g_spare
      assign flags[i] = 1'b0;
   end

   logic unused_clr;
   assign unused_clr = ^clr_mask;

   assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_flag) |-> $past(cap_en));
   assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_mask[0] && !evt) |=> !evt_flag);
   assert_flag_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_flag && !(clr_we && clr_mask[0])) |=> evt_flag);
endmodule

// File: rtl/tpin_drive.sv
module tpin_drive #(
   parameter bit ALLOW_OPEN_DRAIN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] fn,
   input  logic [1:0] pctl,
   input  logic       od,
   output logic       pin_out,
   output logic       pin_oe
);
   import tpin_pkg::*;

   logic drive_en, drive_val, od_eff;

   assign drive_en  = (fn == FN_GPIO) && pctl[1];
   assign drive_val = pctl[0];

   if (ALLOW_OPEN_DRAIN) begin : g_od
      assign od_eff = od;
   end else begin : g_pp_only
      assign od_eff = 1'b0;
      logic unused_od;
      assign unused_od = od;
   end

   always_comb begin
      pin_oe  = 1'b0;
      pin_out = 1'b0;
      if (drive_en) begin
         if (od_eff) begin
            pin_oe = ~drive_val;
         end else begin
            pin_oe  = 1'b1;
            pin_out = drive_val;
         end
      end
   end

   assert_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fn != FN_GPIO) |-> !pin_oe);
   assert_od_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      od_eff |-> !pin_out);
endmodule

// File: rtl/tpin_ctrl.sv
module tpin_ctrl #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int MODE_ADDR   = 0,
   parameter int STATUS_ADDR = 1,
   parameter bit ALLOW_OPEN_DRAIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              pin_in,
   output logic              pin_out,
   output logic              pin_oe,
   output logic              irq
);
   import tpin_pkg::*;

   localparam logic [ADDR_W-1:0] MODE_A   = ADDR_W'(MODE_ADDR);
   localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_ADDR);

   if (DATA_W < MIN_DATA_W) begin : g_bad_width
      $error("tpin_ctrl: DATA_W too small for the mode layout");
   end
   if (MODE_ADDR == STATUS_ADDR) begin : g_bad_addr
      $error("tpin_ctrl: register addresses must differ");
   end

   mode_t mode_q;
   logic  mode_we, stat_we;
   logic  level, cap_en;
   logic [FLAG_W-1:0] flags;

   assign mode_we = bus_we && (bus_addr == MODE_A);
   assign stat_we = bus_we && (bus_addr == STATUS_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (mode_we) begin
         mode_q.fn       <= bus_wdata[FN_LSB +: 3];
         mode_q.pctl     <= bus_wdata[PCTL_LSB +: 2];
         mode_q.irq_en   <= bus_wdata[IRQEN_BIT];
         mode_q.od       <= bus_wdata[OD_BIT];
         mode_q.edge_sel <= bus_wdata[EDGE_LSB +: 2];
      end
   end

   tpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(level));

   assign cap_en = (mode_q.fn == FN_CAPTURE) ||
                   ((mode_q.fn == FN_GPIO) && !mode_q.pctl[1]);

   tpin_capture #(.NFLAG(FLAG_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .level(level), .cap_en(cap_en),
      .edge_sel(mode_q.edge_sel), .clr_we(stat_we),
      .clr_mask(bus_wdata[FLAG_W-1:0]), .flags(flags));

   tpin_drive #(.ALLOW_OPEN_DRAIN(ALLOW_OPEN_DRAIN)) u_drive (
      .clk(clk), .rst_n(rst_n), .fn(mode_q.fn), .pctl(mode_q.pctl),
      .od(mode_q.od), .pin_out(pin_out), .pin_oe(pin_oe));

   assign irq = mode_q.irq_en && (|flags);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == MODE_A) begin
         bus_rdata[FN_LSB +: 3]   = mode_q.fn;
         bus_rdata[PCTL_LSB +: 2] = mode_q.pctl;
         bus_rdata[IRQEN_BIT]     = mode_q.irq_en;
         bus_rdata[OD_BIT]        = mode_q.od;
         bus_rdata[EDGE_LSB +: 2] = mode_q.edge_sel;
      end else if (bus_addr == STATUS_A) begin
         bus_rdata[FLAG_W-1:0]    = flags;
         bus_rdata[LEVEL_BIT]     = level;
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (bus_rdata[IRQEN_BIT] || bus_addr != MODE_A));
endmodule

// File: tb/tpin_ctrl_tb_top.sv
`timescale 1ns/1ps
module tpin_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pin_in = 1'b0;
   logic        pin_out, pin_oe, irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tpin_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

   // {mode word, expected oe, expected out}
   localparam logic [33:0] VEC [12] = '{
      {32'h0000_0000, 1'b0, 1'b0},
      {32'h0000_0001, 1'b0, 1'b0},
      {32'h0000_0032, 1'b0, 1'b0},
      {32'h0000_0033, 1'b0, 1'b0},
      {32'h0000_0034, 1'b1, 1'b1},
      {32'h0000_0024, 1'b1, 1'b0},
      {32'h0000_0004, 1'b0, 1'b0},
      {32'h0000_0014, 1'b0, 1'b0},
      {32'h0000_0234, 1'b0, 1'b0},
      {32'h0000_0224, 1'b1, 1'b0},
      {32'h0000_0035, 1'b0, 1'b0},
      {32'h0000_0037, 1'b0, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a negedge; leaves the bench at the next negedge
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic settle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [31:0] md(input logic [1:0] es, input logic ie, input logic [7:0] low);
      return {14'd0, es, 7'd0, ie, low};
   endfunction

   initial begin
      logic [31:0] r;
      settle(3);
      rst_n = 1'b1;
      settle(1);
      // R1 reset state
      rd(2'd0, r); check("R1 mode", r, 32'h0);
      rd(2'd1, r); check("R1 status", r, 32'h0);
      check("R1 oe/out/irq", {29'd0, pin_oe, pin_out, irq}, 32'h0);

      // table walk: R2 readback, R3..R6 drive
      foreach (VEC[i]) begin
         wr(2'd0, VEC[i][33:2]);
         rd(2'd0, r); check("R2 readback", r, VEC[i][33:2]);
         check("R3-6 drive", {30'd0, pin_oe, pin_out}, {30'd0, VEC[i][1], VEC[i][0]});
      end
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, r); check("R2 undefined bits", r, 32'h0003_0337);
      check("R5 od release", {30'd0, pin_oe, pin_out}, 32'h0);
      wr(2'd0, 32'h0);

      // R7 synchroniser latency
      pin_in = 1'b1;
      settle(1); rd(2'd1, r); check("R7 one edge", r, 32'h0);
      settle(1); rd(2'd1, r); check("R7 two edges", r, 32'h100);
      pin_in = 1'b0; settle(3);

      // R8 edge selects
      wr(2'd0, md(2'b01, 1'b0, 8'h01));
      pin_in = 1'b1; settle(3); rd(2'd1, r); check("R8 rise sel01", r, 32'h101);
      wr(2'd1, 32'hF);
      pin_in = 1'b0; settle(3); rd(2'd1, r); check("R8 fall sel01", r, 32'h0);
      wr(2'd0, md(2'b10, 1'b0, 8'h01));
      pin_in = 1'b1; settle(3); rd(2'd1, r); check("R8 rise sel10", r, 32'h100);
      pin_in = 1'b0; settle(3); rd(2'd1, r); check("R8 fall sel10", r, 32'h1);
      wr(2'd1, 32'h1);
      wr(2'd0, md(2'b00, 1'b0, 8'h01));
      pin_in = 1'b1; settle(3); pin_in = 1'b0; settle(3);
      rd(2'd1, r); check("R8 sel00", r, 32'h0);
      wr(2'd0, md(2'b11, 1'b0, 8'h01));
      pin_in = 1'b1; settle(3); rd(2'd1, r); check("R8 both rise", r, 32'h101);
      // R9 missed event
      pin_in = 1'b0; settle(3); rd(2'd1, r); check("R9 miss", r, 32'h3);
      // R10 selective clear
      wr(2'd1, 32'h2); rd(2'd1, r); check("R10 clear bit1", r, 32'h1);
      wr(2'd1, 32'h0); rd(2'd1, r); check("R10 zero write", r, 32'h1);
      wr(2'd1, 32'h1); rd(2'd1, r); check("R10 clear bit0", r, 32'h0);
      // R10 event wins over same-cycle clear
      pin_in = 1'b1; settle(2);
      wr(2'd1, 32'h1);
      rd(2'd1, r); check("R10 set wins", r, 32'h101);
      // R11 interrupt mask
      check("R11 masked", {31'd0, irq}, 32'h0);
      wr(2'd0, md(2'b11, 1'b1, 8'h01));
      check("R11 enabled", {31'd0, irq}, 32'h1);
      wr(2'd0, md(2'b11, 1'b0, 8'h01));
      rd(2'd1, r);
      check("R11 mask keeps flag", {r[31:0]}, 32'h101);
      check("R11 irq low", {31'd0, irq}, 32'h0);
      wr(2'd1, 32'hF);

      // R12 no false event on reconfiguration, pin held high
      wr(2'd0, 32'h0); settle(2);
      wr(2'd0, md(2'b11, 1'b0, 8'h01)); settle(3);
      rd(2'd1, r); check("R12 enter capture", r, 32'h100);
      wr(2'd0, md(2'b01, 1'b0, 8'h01)); settle(3);
      rd(2'd1, r); check("R12 change select", r, 32'h100);

      // R13 capture as GPIO input, not as output
      wr(2'd0, md(2'b10, 1'b0, 8'h04));
      pin_in = 1'b0; settle(3); rd(2'd1, r); check("R13 gpio input capture", r, 32'h1);
      check("R4 input oe", {31'd0, pin_oe}, 32'h0);
      wr(2'd1, 32'hF);
      wr(2'd0, md(2'b11, 1'b0, 8'h34));
      pin_in = 1'b1; settle(3); pin_in = 1'b0; settle(3);
      rd(2'd1, r); check("R13 output no capture", r, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule